// File: doc/BRIEF.md
# Radix Page Table Walker

This block turns a virtual address into a physical page number. It walks a multi-level radix page table that sits in memory. One walker serves three table geometries, and the geometry is chosen per request: a two-level table with 4-byte entries, and a three-level or four-level table with 8-byte entries. For each request the caller supplies:

- the virtual address,
- the kind of access (instruction fetch, data load or data store),
- whether the access runs with supervisor or user rights,
- two status flags: one that blocks supervisor access to user pages, and one that lets loads read execute-only pages,
- the page number of the root table.

The walker reads one entry per level through a small memory port. Each entry is either a pointer to the next level or a leaf. The walker checks the leaf against the request's rights. When the leaf passes, the walker writes the entry back with the accessed flag set, and with the dirty flag set too for a store. It then reports the physical page number, or it reports a fault. A leaf found above the lowest level maps a large page. In that case the virtual page bits below that level are merged into the result.

The request port accepts one walk at a time. `req_ready` is high only while the walker is idle, and a request is taken on a cycle where `req_valid` and `req_ready` are both high. The memory request port follows valid/ready rules. Once the walker raises `mem_req_valid`, it holds the address, the direction and the write data unchanged until the memory raises `mem_req_ready`. A read is then answered by exactly one `mem_rsp_valid` cycle, after a delay the memory may choose. A write gets no answer. The memory may hold `mem_req_ready` low for as long as it likes. The end of a walk is a one-cycle `done` pulse, which carries `fault` and `done_ppn`.

Top module: `ptw_walker`

## Requirements
- R1: `req_mode` selects the geometry: 0 gives 2 levels, 10 index bits and 4-byte entries; 1 gives 3 levels, 9 index bits and 8-byte entries; 2 gives 4 levels, 9 index bits and 8-byte entries. Code 3 faults with no memory access. `req_kind` is 0 for fetch, 1 for load and 2 for store.
- R2: The virtual width is 12 + levels × index bits. Address bits from 63 down to (width − 1) must all be equal. If they are not, the walk faults with no memory access.
- R3: Entry addresses are read in order. Each address is (table page number << 12) + index × entry size. The first index comes from the highest index field of the address, and each later level uses the next lower field.
- R4: An entry with V (bit 0) set and R (bit 1), W (bit 2) and X (bit 3) all clear is a pointer. Its page number (bits from 10 upward) becomes the next table. A pointer found at the lowest level is a fault.
- R5: An entry with V clear faults, even when R, W and X are all clear. An entry with W set and R clear also faults.
- R6: For a leaf with U (bit 4) set, a supervisor request faults when `req_pum` is set and succeeds when it is clear. For a leaf with U clear, a user request faults.
- R7: A fetch needs X. A load needs R, or needs X while `req_mxr` is set. A store needs both R and W.
- R8: A successful leaf causes exactly one write, to the leaf's own address. The data is the entry with A (bit 6) set, plus D (bit 7) for a store, and every other bit unchanged. A faulting walk writes nothing.
- R9: A leaf found at level L > 0 returns its page number ORed with the low L × (index bits) bits of the virtual page number.
- R10: An entry address outside the window [`MEM_LO`, `MEM_HI`) faults without being read.
- R11: A memory request stays valid and unchanged until it is accepted. Each accepted read waits for one response. The walker issues no request while idle.
- R12: `done` is high for exactly one cycle per walk, and the walker is ready again on the next cycle. On a fault, `done_ppn` is 0.
- R13: After reset the walker is idle and ready, with `done` and `mem_req_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Walk request present |
| req_ready | output | 1 | Walker idle and accepting |
| req_vaddr | input | 64 | Virtual address |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| req_super | input | 1 | 1 = supervisor rights, 0 = user |
| req_pum | input | 1 | Block supervisor access to user pages |
| req_mxr | input | 1 | Loads may read execute-only pages |
| req_mode | input | 2 | Table geometry select |
| root_ppn | input | 44 | Page number of the root table |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 56 | Entry byte address |
| mem_req_wdata | output | 64 | Updated entry for writes |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Read data |
| done | output | 1 | Walk finished (one cycle) |
| fault | output | 1 | Walk failed, valid with done |
| done_ppn | output | 44 | Physical page number, valid with done |

## Verification
A broken level counter or base register shows up straight away as a wrong address on the next memory read. The bench compares every accepted read against the expected address sequence at the cycle of the handshake. A fault decision that goes wrong shows up two ways: an extra or missing write-back within a few cycles of the leaf response, and a wrong `fault` or `done_ppn` value on the `done` pulse. Stalls on `mem_req_ready` and delayed responses are mixed in all through the run, so a walker that loses a request or misreads a response either stalls into a timeout or sends a request out of order.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_NONE  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    GEO_L2W10 = 2'd0,
    GEO_L3W9  = 2'd1,
    GEO_L4W9  = 2'd2,
    GEO_RSVD  = 2'd3
  } geo_sel_e;

  // entry flag positions
  localparam int unsigned EF_V = 0;
  localparam int unsigned EF_R = 1;
  localparam int unsigned EF_W = 2;
  localparam int unsigned EF_X = 3;
  localparam int unsigned EF_U = 4;
  localparam int unsigned EF_A = 6;
  localparam int unsigned EF_D = 7;
  localparam int unsigned EF_PN_LSB = 10;

  typedef enum logic [2:0] {
    WK_IDLE  = 3'd0,
    WK_ADDR  = 3'd1,
    WK_RREQ  = 3'd2,
    WK_RWAIT = 3'd3,
    WK_EVAL  = 3'd4,
    WK_WREQ  = 3'd5,
    WK_DONE  = 3'd6
  } walk_st_e;

endpackage

// File: rtl/ptw_geom.sv
module ptw_geom
  import ptw_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [1:0]      mode,
  input  logic [XLEN-1:0] vaddr,
  output logic [2:0]      levels,
  output logic [3:0]      idx_bits,
  output logic            wide,
  output logic            canon_ok
);
  logic [5:0]      va_bits;
  logic            known;
  logic [5:0]      sh;
  logic [XLEN-1:0] hi_bits;
  logic [XLEN-1:0] ones;

  always_comb begin
    levels   = 3'd0;
    idx_bits = 4'd0;
    wide     = 1'b0;
    va_bits  = 6'd1;
    known    = 1'b0;
    case (geo_sel_e'(mode))
      GEO_L2W10: begin levels = 3'd2; idx_bits = 4'd10; wide = 1'b0; va_bits = 6'd32; known = 1'b1; end
      GEO_L3W9:  begin levels = 3'd3; idx_bits = 4'd9;  wide = 1'b1; va_bits = 6'd39; known = 1'b1; end
      GEO_L4W9:  begin levels = 3'd4; idx_bits = 4'd9;  wide = 1'b1; va_bits = 6'd48; known = 1'b1; end
      default:   begin levels = 3'd0; idx_bits = 4'd0;  wide = 1'b0; va_bits = 6'd1;  known = 1'b0; end
    endcase
    // bits from the top down to va_bits-1 must all match
    sh       = va_bits - 6'd1;
    hi_bits  = vaddr >> sh;
    ones     = {XLEN{1'b1}} >> sh;
    canon_ok = known && ((hi_bits == '0) || (hi_bits == ones));
  end

endmodule

// File: rtl/ptw_addr.sv
module ptw_addr #(
  parameter int XLEN    = 64,
  parameter int PGSHIFT = 12,
  parameter int PA_W    = 56,
  parameter int PPN_W   = PA_W - PGSHIFT,
  parameter logic [PA_W-1:0] MEM_LO = '0,
  parameter logic [PA_W-1:0] MEM_HI = '1
) (
  input  logic [PPN_W-1:0] base_ppn,
  input  logic [XLEN-1:0]  vaddr,
  input  logic [1:0]       lvl,
  input  logic [3:0]       idx_bits,
  input  logic             wide,
  input  logic [PPN_W-1:0] pte_ppn,
  output logic [PA_W-1:0]  pte_addr,
  output logic             addr_legal,
  output logic [PPN_W-1:0] leaf_ppn
);
  localparam int SHW = 7;

  logic [SHW-1:0]   lvl_shift;
  logic [SHW-1:0]   idx_shift;
  logic [9:0]       idx_mask;
  logic [9:0]       idx;
  logic [PA_W-1:0]  offset;
  logic [PPN_W-1:0] vpn;
  logic [PPN_W-1:0] low_mask;

  always_comb begin
    lvl_shift  = SHW'(lvl) * SHW'(idx_bits);
    idx_shift  = SHW'(PGSHIFT) + lvl_shift;
    idx_mask   = ~(10'h3ff << idx_bits);
    idx        = 10'(vaddr >> idx_shift) & idx_mask;
    offset     = wide ? (PA_W'(idx) << 3) : (PA_W'(idx) << 2);
    pte_addr   = {base_ppn, {PGSHIFT{1'b0}}} + offset;
    addr_legal = (pte_addr >= MEM_LO) && (pte_addr < MEM_HI);
    // large page: low virtual page bits below this level fill the result
    vpn        = vaddr[PGSHIFT +: PPN_W];
    low_mask   = ~({PPN_W{1'b1}} << lvl_shift);
    leaf_ppn   = pte_ppn | (vpn & low_mask);
  end

endmodule

// File: rtl/ptw_perm.sv
module ptw_perm
  import ptw_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] pte,
  input  logic [1:0]      kind,
  input  logic            sup,
  input  logic            pum,
  input  logic            mxr,
  output logic            is_ptr,
  output logic            leaf_ok,
  output logic [XLEN-1:0] wb_data
);
  logic v, r, w, x, u;
  logic priv_bad, form_bad, acc_bad;

  always_comb begin
    v = pte[EF_V];
    r = pte[EF_R];
    w = pte[EF_W];
    x = pte[EF_X];
    u = pte[EF_U];
    is_ptr   = v & ~r & ~w & ~x;
    priv_bad = u ? (sup & pum) : ~sup;
    form_bad = ~v | (w & ~r);
    case (acc_kind_e'(kind))
      ACC_FETCH: acc_bad = ~x;
      ACC_LOAD:  acc_bad = ~(r | (mxr & x));
      ACC_STORE: acc_bad = ~(r & w);
      default:   acc_bad = 1'b1;
    endcase
    leaf_ok = ~is_ptr & ~priv_bad & ~form_bad & ~acc_bad;
    wb_data = pte | (XLEN'(1) << EF_A)
                  | ((acc_kind_e'(kind) == ACC_STORE) ? (XLEN'(1) << EF_D) : '0);
  end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int XLEN    = 64,
  parameter int PGSHIFT = 12,
  parameter int PA_W    = 56,
  parameter logic [PA_W-1:0] MEM_LO = PA_W'(64'h8000_0000),
  parameter logic [PA_W-1:0] MEM_HI = PA_W'(64'h1_0000_0000)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [XLEN-1:0]           req_vaddr,
  input  logic [1:0]                req_kind,
  input  logic                      req_super,
  input  logic                      req_pum,
  input  logic                      req_mxr,
  input  logic [1:0]                req_mode,
  input  logic [PA_W-PGSHIFT-1:0]   root_ppn,
  output logic                      mem_req_valid,
  input  logic                      mem_req_ready,
  output logic                      mem_req_write,
  output logic [PA_W-1:0]           mem_req_addr,
  output logic [XLEN-1:0]           mem_req_wdata,
  input  logic                      mem_rsp_valid,
  input  logic [XLEN-1:0]           mem_rsp_data,
  output logic                      done,
  output logic                      fault,
  output logic [PA_W-PGSHIFT-1:0]   done_ppn
);
  localparam int PPN_W = PA_W - PGSHIFT;

  typedef struct packed {
    logic [XLEN-1:0] vaddr;
    logic [1:0]      kind;
    logic            sup;
    logic            pum;
    logic            mxr;
    logic [1:0]      mode;
  } walk_req_t;

  walk_st_e         st_q;
  walk_req_t        rq_q;
  logic [PPN_W-1:0] base_q;
  logic [1:0]       lvl_q;
  logic [XLEN-1:0]  pte_q;
  logic [PA_W-1:0]  addr_q;
  logic             fault_q;
  logic [PPN_W-1:0] ppn_q;

  logic [1:0]       cur_mode;
  logic [XLEN-1:0]  cur_va;
  logic [2:0]       levels;
  logic [3:0]       idx_bits;
  logic             wide;
  logic             canon_ok;
  logic [PA_W-1:0]  pte_addr;
  logic             addr_legal;
  logic [PPN_W-1:0] leaf_ppn;
  logic             is_ptr;
  logic             leaf_ok;
  logic [XLEN-1:0]  wb_data;
  logic [XLEN-1:0]  rsp_word;

  assign cur_mode = (st_q == WK_IDLE) ? req_mode  : rq_q.mode;
  assign cur_va   = (st_q == WK_IDLE) ? req_vaddr : rq_q.vaddr;

  ptw_geom #(.XLEN(XLEN)) u_geom (
    .mode     (cur_mode),
    .vaddr    (cur_va),
    .levels   (levels),
    .idx_bits (idx_bits),
    .wide     (wide),
    .canon_ok (canon_ok)
  );

  ptw_addr #(
    .XLEN(XLEN), .PGSHIFT(PGSHIFT), .PA_W(PA_W), .PPN_W(PPN_W),
    .MEM_LO(MEM_LO), .MEM_HI(MEM_HI)
  ) u_addr (
    .base_ppn   (base_q),
    .vaddr      (rq_q.vaddr),
    .lvl        (lvl_q),
    .idx_bits   (idx_bits),
    .wide       (wide),
    .pte_ppn    (pte_q[EF_PN_LSB +: PPN_W]),
    .pte_addr   (pte_addr),
    .addr_legal (addr_legal),
    .leaf_ppn   (leaf_ppn)
  );

  ptw_perm #(.XLEN(XLEN)) u_perm (
    .pte     (pte_q),
    .kind    (rq_q.kind),
    .sup     (rq_q.sup),
    .pum     (rq_q.pum),
    .mxr     (rq_q.mxr),
    .is_ptr  (is_ptr),
    .leaf_ok (leaf_ok),
    .wb_data (wb_data)
  );

  // narrow entries keep only their low half
  assign rsp_word = wide ? mem_rsp_data : {{(XLEN-32){1'b0}}, mem_rsp_data[31:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WK_IDLE;
      rq_q    <= '0;
      base_q  <= '0;
      lvl_q   <= '0;
      pte_q   <= '0;
      addr_q  <= '0;
      fault_q <= 1'b0;
      ppn_q   <= '0;
    end else begin
      case (st_q)
        WK_IDLE: begin
          if (req_valid) begin
            rq_q    <= '{vaddr: req_vaddr, kind: req_kind, sup: req_super,
                         pum: req_pum, mxr: req_mxr, mode: req_mode};
            base_q  <= root_ppn;
            lvl_q   <= 2'(levels - 3'd1);
            fault_q <= 1'b0;
            ppn_q   <= '0;
            if (canon_ok) begin
              st_q <= WK_ADDR;
            end else begin
              fault_q <= 1'b1;
              st_q    <= WK_DONE;
            end
          end
        end
        WK_ADDR: begin
          if (addr_legal) begin
            addr_q <= pte_addr;
            st_q   <= WK_RREQ;
          end else begin
            fault_q <= 1'b1;
            st_q    <= WK_DONE;
          end
        end
        WK_RREQ: begin
          if (mem_req_ready) st_q <= WK_RWAIT;
        end
        WK_RWAIT: begin
          if (mem_rsp_valid) begin
            pte_q <= rsp_word;
            st_q  <= WK_EVAL;
          end
        end
        WK_EVAL: begin
          if (is_ptr) begin
            if (lvl_q == 2'd0) begin
              fault_q <= 1'b1;
              st_q    <= WK_DONE;
            end else begin
              base_q <= pte_q[EF_PN_LSB +: PPN_W];
              lvl_q  <= lvl_q - 2'd1;
              st_q   <= WK_ADDR;
            end
          end else if (leaf_ok) begin
            ppn_q <= leaf_ppn;
            st_q  <= WK_WREQ;
          end else begin
            fault_q <= 1'b1;
            st_q    <= WK_DONE;
          end
        end
        WK_WREQ: begin
          if (mem_req_ready) st_q <= WK_DONE;
        end
        WK_DONE: st_q <= WK_IDLE;
        default: st_q <= WK_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready     = (st_q == WK_IDLE);
    mem_req_valid = (st_q == WK_RREQ) || (st_q == WK_WREQ);
    mem_req_write = (st_q == WK_WREQ);
    mem_req_addr  = addr_q;
    mem_req_wdata = (st_q == WK_WREQ) ? wb_data : '0;
    done          = (st_q == WK_DONE);
    fault         = done & fault_q;
    done_ppn      = done ? ppn_q : '0;
  end

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int XLEN  = 64,
  parameter int PA_W  = 56,
  parameter int PPN_W = 44
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic             mem_req_write,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic [XLEN-1:0]  mem_req_wdata,
  input logic             done,
  input logic             fault,
  input logic [PPN_W-1:0] done_ppn
);

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid);

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r12_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);

  a_r12_fault_zero_ppn: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (done_ppn == '0));

  a_r8_wb_accessed: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_write) |-> mem_req_wdata[6]);

  a_r8_wb_then_ok: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && mem_req_write) |=> (done && !fault));

endmodule

bind ptw_walker ptw_walker_chk #(.XLEN(XLEN), .PA_W(PA_W), .PPN_W(PPN_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .done          (done),
  .fault         (fault),
  .done_ppn      (done_ppn)
);

// File: tb/ptw_walker_tb_top.sv
module ptw_walker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN  = 64;
  localparam int PA_W  = 56;
  localparam int PPN_W = 44;
  localparam logic [63:0] LO = 64'h8000_0000;
  localparam logic [63:0] HI = 64'h1_0000_0000;
  localparam logic [7:0] FV = 8'h01, FR = 8'h02, FW = 8'h04, FX = 8'h08, FU = 8'h10;
  localparam logic [43:0] ROOT = 44'h80000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [63:0]      req_vaddr = '0;
  logic [1:0]       req_kind = '0;
  logic             req_super = 1'b0;
  logic             req_pum = 1'b0;
  logic             req_mxr = 1'b0;
  logic [1:0]       req_mode = '0;
  logic [43:0]      root_ppn = ROOT;
  logic             mem_req_valid;
  logic             mem_req_ready = 1'b0;
  logic             mem_req_write;
  logic [55:0]      mem_req_addr;
  logic [63:0]      mem_req_wdata;
  logic             mem_rsp_valid = 1'b0;
  logic [63:0]      mem_rsp_data = '0;
  logic             done;
  logic             fault;
  logic [43:0]      done_ppn;

  ptw_walker dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_super(req_super), .req_pum(req_pum), .req_mxr(req_mxr),
    .req_mode(req_mode), .root_ppn(root_ppn),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault), .done_ppn(done_ppn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  logic [63:0] mem [logic [63:0]];
  logic [63:0] exp_rd [$];
  logic [63:0] exp_wa [$];
  logic [63:0] exp_wd [$];
  bit          ref_fault;
  logic [43:0] ref_ppn;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_pte(input logic [43:0] ppn, input logic [7:0] fl);
    return ({20'd0, ppn} << 10) | {56'd0, fl};
  endfunction

  function automatic void geo(input logic [1:0] mode, output int lv, output int bits, output int esz);
    case (mode)
      2'd0: begin lv = 2; bits = 10; esz = 4; end
      2'd1: begin lv = 3; bits = 9;  esz = 8; end
      2'd2: begin lv = 4; bits = 9;  esz = 8; end
      default: begin lv = 0; bits = 0; esz = 0; end
    endcase
  endfunction

  function automatic logic [63:0] vidx(input logic [63:0] va, input int lvl, input int bits);
    return (va >> (12 + lvl * bits)) & ((64'd1 << bits) - 64'd1);
  endfunction

  function automatic logic [63:0] eaddr(input logic [43:0] ppn, input logic [63:0] idx, input int esz);
    return ({20'd0, ppn} << 12) + idx * 64'(esz);
  endfunction

  // table chain from the root: pointers down to leaf_lvl, leaf entry there
  task automatic build(input logic [1:0] mode, input logic [63:0] va, input int leaf_lvl,
                       input logic [7:0] leaf_fl, input logic [43:0] leaf_ppn);
    int lv, bits, esz;
    logic [43:0] tbl;
    geo(mode, lv, bits, esz);
    mem.delete();
    tbl = ROOT;
    for (int l = lv - 1; l >= leaf_lvl; l--) begin
      if (l == leaf_lvl) mem[eaddr(tbl, vidx(va, l, bits), esz)] = mk_pte(leaf_ppn, leaf_fl);
      else begin
        mem[eaddr(tbl, vidx(va, l, bits), esz)] = mk_pte(tbl + 44'd1, FV);
        tbl = tbl + 44'd1;
      end
    end
  endtask

  // behavioural reference: expected reads, write and result
  task automatic ref_walk(input logic [63:0] va, input logic [1:0] kind, input bit sup,
                          input bit pum, input bit mxr, input logic [1:0] mode);
    int lv, bits, esz, n;
    logic [63:0] hi, ones, a, p, base;
    logic [43:0] ppn;
    bit v, r, w, x, u, bad;
    geo(mode, lv, bits, esz);
    ref_fault = 1'b1;
    ref_ppn = '0;
    if (lv == 0) return;
    n = 12 + lv * bits;
    hi = va >> (n - 1);
    ones = ~64'd0 >> (n - 1);
    if (hi != 0 && hi != ones) return;
    base = {20'd0, ROOT};
    for (int l = lv - 1; l >= 0; l--) begin
      a = (base << 12) + vidx(va, l, bits) * 64'(esz);
      if (a < LO || a >= HI) return;
      exp_rd.push_back(a);
      p = mem.exists(a) ? mem[a] : 64'd0;
      if (esz == 4) p = p & 64'hFFFF_FFFF;
      v = p[0]; r = p[1]; w = p[2]; x = p[3]; u = p[4];
      ppn = p[53:10];
      if (v && !r && !w && !x) begin
        base = {20'd0, ppn};
        continue;
      end
      bad = u ? (sup && pum) : !sup;
      if (!v || (w && !r)) bad = 1'b1;
      case (kind)
        2'd0: if (!x) bad = 1'b1;
        2'd1: if (!(r || (mxr && x))) bad = 1'b1;
        2'd2: if (!(r && w)) bad = 1'b1;
        default: bad = 1'b1;
      endcase
      if (bad) return;
      exp_wa.push_back(a);
      exp_wd.push_back(p | 64'h40 | ((kind == 2'd2) ? 64'h80 : 64'h0));
      ref_fault = 1'b0;
      ref_ppn = ppn | (va[55:12] & ~(44'hFFF_FFFF_FFFF << (l * bits)));
      return;
    end
  endtask

  // memory model with stalls and delayed responses
  logic [15:0] lfsr = 16'hACE1;
  bit rsp_pend = 1'b0;
  int rsp_cnt = 0;
  logic [63:0] rsp_word;

  always @(negedge clk) begin
    logic [63:0] a, e;
    if (rst_n) begin
      mem_rsp_valid = 1'b0;
      if (rsp_pend) begin
        if (rsp_cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data = rsp_word;
          rsp_pend = 1'b0;
        end else rsp_cnt--;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_req_ready = lfsr[0] | lfsr[3];
      if (mem_req_valid && mem_req_ready) begin
        a = {8'd0, mem_req_addr};
        if (!mem_req_write) begin
          if (exp_rd.size() == 0) chk(1'b0, "R11", "unexpected read", a, 64'd0);
          else begin
            e = exp_rd.pop_front();
            chk(a == e, "R3", "entry read address", a, e);
          end
          rsp_word = mem.exists(a) ? mem[a] : 64'd0;
          rsp_pend = 1'b1;
          rsp_cnt = int'(lfsr[5:4]);
        end else begin
          if (exp_wa.size() == 0) chk(1'b0, "R8", "unexpected write", a, 64'd0);
          else begin
            e = exp_wa.pop_front();
            chk(a == e, "R8", "write-back address", a, e);
            e = exp_wd.pop_front();
            chk(mem_req_wdata == e, "R8", "write-back data", mem_req_wdata, e);
          end
          mem[a] = mem_req_wdata;
        end
      end
    end
  end

  task automatic run_walk(input string tag, input logic [63:0] va, input logic [1:0] kind,
                          input bit sup, input bit pum, input bit mxr, input logic [1:0] mode,
                          input bit want_fault, input logic [43:0] want_ppn);
    int cnt;
    exp_rd.delete(); exp_wa.delete(); exp_wd.delete();
    ref_walk(va, kind, sup, pum, mxr, mode);
    @(negedge clk);
    chk(req_ready == 1'b1, "R12", "ready before request", {63'd0, req_ready}, 64'd1);
    req_vaddr = va; req_kind = kind; req_super = sup; req_pum = pum;
    req_mxr = mxr; req_mode = mode; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cnt = 0;
    while (!done && cnt < 400) begin
      @(negedge clk);
      cnt++;
    end
    if (!done) chk(1'b0, tag, "walk timeout", 64'd0, 64'd1);
    else begin
      chk(fault == want_fault, tag, "fault flag", {63'd0, fault}, {63'd0, want_fault});
      if (!want_fault) chk(done_ppn == want_ppn, tag, "page number", {20'd0, done_ppn}, {20'd0, want_ppn});
      else chk(done_ppn == '0, "R12", "ppn on fault", {20'd0, done_ppn}, 64'd0);
      chk(exp_rd.size() == 0, "R11", "reads missing", 64'(exp_rd.size()), 64'd0);
      chk(exp_wa.size() == 0, "R8", "write missing", 64'(exp_wa.size()), 64'd0);
      @(negedge clk);
      chk(done == 1'b0, "R12", "done width", {63'd0, done}, 64'd0);
    end
  endtask

  initial begin
    repeat (2000 * 50) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] va39, va48, va32, vhi;
    va39 = 64'h4060_3ABC;
    va48 = (64'd2 << 39) | (64'd1 << 30) | (64'd5 << 21) | (64'd7 << 12) | 64'h10;
    va32 = 64'h48C2_A5C4;
    vhi  = 64'hFFFF_FFC0_0000_0000;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0 && mem_req_valid == 1'b0, "R13", "reset state",
        {61'd0, req_ready, done, mem_req_valid}, 64'h4);
    rst_n = 1'b1;

    // R3 / R8: three-level 4K page, user load and store
    build(2'd1, va39, 0, FV | FR | FU, 44'h12345);
    run_walk("R3", va39, 2'd1, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 44'h12345);
    chk(mem[eaddr(44'h80002, vidx(va39, 0, 9), 8)][7:6] == 2'b01, "R8", "accessed set, dirty clear",
        {62'd0, mem[eaddr(44'h80002, vidx(va39, 0, 9), 8)][7:6]}, 64'd1);
    build(2'd1, va39, 0, FV | FR | FW | FU, 44'h12345);
    run_walk("R8", va39, 2'd2, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 44'h12345);
    // R9: large pages
    build(2'd1, va39, 2, FV | FR | FU, 44'h40000);
    run_walk("R9", va39, 2'd1, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 44'h40603);
    build(2'd2, va48, 1, FV | FX, 44'h30000);
    run_walk("R9", va48, 2'd0, 1'b1, 1'b0, 1'b0, 2'd2, 1'b0, 44'h30007);
    // R1: two-level geometry, 4K and large page
    build(2'd0, va32, 0, FV | FR | FW | FU, 44'h5555);
    run_walk("R1", va32, 2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 44'h5555);
    build(2'd0, va32, 1, FV | FR, 44'h1400);
    run_walk("R1", va32, 2'd1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 44'h142A);
    run_walk("R1", va39, 2'd1, 1'b1, 1'b0, 1'b0, 2'd3, 1'b1, 44'h0);
    // R2: canonical checks
    build(2'd1, vhi, 2, FV | FR, 44'h70000);
    run_walk("R2", vhi, 2'd1, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 44'h70000);
    run_walk("R2", 64'h0000_0080_0000_0000, 2'd1, 1'b1, 1'b0, 1'b0, 2'd1, 1'b1, 44'h0);
    run_walk("R2", 64'h0000_0000_8000_0000, 2'd1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 44'h0);
    // R5: invalid pointer, W without R
    build(2'd1, va39, 0, FV | FR | FU, 44'h12345);
    mem[eaddr(ROOT, vidx(va39, 2, 9), 8)] = mk_pte(44'h80001, 8'h00);
    run_walk("R5", va39, 2'd1, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 44'h0);
    build(2'd1, va39, 0, FV | FW | FU, 44'h12345);
    run_walk("R5", va39, 2'd1, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 44'h0);
    // R6: privilege rules
    build(2'd1, va39, 0, FV | FR | FU, 44'h222);
    run_walk("R6", va39, 2'd1, 1'b1, 1'b1, 1'b0, 2'd1, 1'b1, 44'h0);
    run_walk("R6", va39, 2'd1, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 44'h222);
    build(2'd1, va39, 0, FV | FR, 44'h222);
    run_walk("R6", va39, 2'd1, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 44'h0);
    // R7: access kinds
    build(2'd1, va39, 0, FV | FR, 44'h333);
    run_walk("R7", va39, 2'd0, 1'b1, 1'b0, 1'b0, 2'd1, 1'b1, 44'h0);
    run_walk("R7", va39, 2'd2, 1'b1, 1'b0, 1'b0, 2'd1, 1'b1, 44'h0);
    build(2'd1, va39, 0, FV | FX, 44'h333);
    run_walk("R7", va39, 2'd1, 1'b1, 1'b0, 1'b0, 2'd1, 1'b1, 44'h0);
    run_walk("R7", va39, 2'd1, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 44'h333);
    // R4: pointer at the lowest level
    build(2'd1, va39, 0, FV, 44'h80005);
    run_walk("R4", va39, 2'd1, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 44'h0);
    // R10: next table outside the memory window
    build(2'd1, va39, 0, FV | FR | FU, 44'h12345);
    mem[eaddr(ROOT, vidx(va39, 2, 9), 8)] = mk_pte(44'h10, FV);
    run_walk("R10", va39, 2'd1, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 44'h0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule